// File: doc/BRIEF.md
# Half-to-Single Precision Widening Converter

This block turns a 16-bit half-precision floating-point value into its exact 32-bit single-precision equivalent. The half operand is taken from one of the two 16-bit halves of a 32-bit source word. A lane select chooses either the low half or the high half. A control word supplies a format bit. When that bit is clear, the operand is read as a standard IEEE half. When it is set, the operand uses an alternative half format. In the alternative format the top exponent code is an ordinary finite binade, so the format has no infinities and no NaNs.

The conversion never rounds, because every half value can be written exactly as a single. Half subnormals become single normals: the leading one is moved up to the hidden-bit position, and the exponent is adjusted to match. In IEEE mode, every NaN leaves the block in quiet form. A signaling NaN input also raises an invalid-operation flag. The result and the flag are captured one clock after a valid input strobe, and they hold until the next strobe.

Top module: `half_widen_top`

## Requirements
- R1: `laneSel` = 0 takes the half from `srcWord[15:0]`. `laneSel` = 1 takes it from `srcWord[31:16]`. The lane that is not selected has no effect on the outputs.
- R2: A half with exponent field 0 and fraction 0 yields a single zero with the same sign (bit 31), and bits 30:0 clear.
- R3: A half with exponent field 1..30 yields sign unchanged, single exponent = half exponent + 112, single fraction = half fraction in bits 22:13, and bits 12:0 zero.
- R4: A half with exponent field 0 and a nonzero fraction has its highest set fraction bit at index p (0..9). It yields single exponent p + 103, and the single fraction is the half fraction shifted left by 10 − p, with the leading one dropped and the result placed in bits 22:13.
- R5: In IEEE mode (`fpCtrl[26]` = 0), half exponent field 31 yields single exponent 255, with the fraction copied to bits 22:13. When the fraction is nonzero, bit 22 is forced to 1.
- R6: In alternative mode (`fpCtrl[26]` = 1), half exponent field 31 is converted as a finite normal number, giving single exponent 143. The other bits of `fpCtrl` have no effect in either mode.
- R7: `invalidOp` is 1 only in IEEE mode when the input has exponent 31, a nonzero fraction and fraction bit 9 clear. It is 0 for every other input.
- R8: `result` and `invalidOp` appear on the first rising edge after a cycle with `inValid` high. `outValid` is high in exactly the cycle that follows each input strobe.
- R9: Synchronous active-high `rst` clears `result`, `invalidOp` and `outValid` at the next rising edge.
- R10: While `inValid` is low, `result` and `invalidOp` hold their last values, whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input strobe: capture a conversion this cycle |
| srcWord | input | 32 | Source word holding two half lanes |
| laneSel | input | 1 | 0 selects bits 15:0, 1 selects bits 31:16 |
| fpCtrl | input | 32 | Control word; bit 26 selects the alternative format |
| result | output | 32 | Single-precision result |
| invalidOp | output | 1 | Signaling NaN seen in IEEE mode |
| outValid | output | 1 | Result strobe, one cycle after `inValid` |

## Verification
The hardest inputs to reach are the exponent-31 codes, which have two opposite meanings depending on the mode bit. Among them, the signaling NaNs are only the 511 codes per sign that have fraction bit 9 clear. The subnormal path also needs all ten leading-one positions to prove that the shift amount and the exponent correction agree. The stimulus therefore streams every one of the 65536 half codes back to back, once in each mode. It alternates the lane, puts unrelated data in the other lane and scrambles the other control bits. Each output is compared one cycle later against a model that finds the leading one by scanning, not by encoding.

// File: rtl/hw_pkg.sv
package hw_pkg;
  localparam int H_EXP_W   = 5;
  localparam int H_FRAC_W  = 10;
  localparam int S_EXP_W   = 8;
  localparam int S_FRAC_W  = 23;
  localparam int H_W       = 1 + H_EXP_W + H_FRAC_W;
  localparam int S_W       = 1 + S_EXP_W + S_FRAC_W;
  localparam int H_BIAS    = (1 << (H_EXP_W - 1)) - 1;
  localparam int S_BIAS    = (1 << (S_EXP_W - 1)) - 1;
  localparam int BIAS_GAP  = S_BIAS - H_BIAS;
  localparam int FRAC_PAD  = S_FRAC_W - H_FRAC_W;
  localparam int LEAD_W    = $clog2(H_FRAC_W + 1);

  typedef struct packed {
    logic capture;
    logic clear;
  } ctrlStrobe_t;
endpackage

// File: rtl/hw_lane_pick.sv
module hw_lane_pick #(
  parameter int SRC_W  = 32,
  parameter int LANE_W = 16,
  localparam int LANES = SRC_W / LANE_W,
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [SRC_W-1:0]  srcWord,
  input  logic [SEL_W-1:0]  laneSel,
  output logic [LANE_W-1:0] laneVal
);
  logic [LANE_W-1:0] lanes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign lanes[g] = srcWord[g*LANE_W +: LANE_W];
  end

  always_comb begin
    laneVal = lanes[0];
    for (int i = 0; i < LANES; i++) begin
      if (SEL_W'(i) == laneSel) laneVal = lanes[i];
    end
  end
endmodule

// File: rtl/hw_ctrl.sv
module hw_ctrl
  import hw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output ctrlStrobe_t strobe,
  output logic        outValid
);
  always_comb begin
    strobe.clear   = rst;
    strobe.capture = inValid && !rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
  a_r9_valid_cleared: assert property (@(posedge clk)
    rst |=> !outValid);
endmodule

// File: rtl/hw_datapath.sv
module hw_datapath
  import hw_pkg::*;
(
  input  logic             clk,
  input  ctrlStrobe_t      strobe,
  input  logic [H_W-1:0]   halfIn,
  input  logic             altMode,
  output logic [S_W-1:0]   result,
  output logic             invalidOp
);
  logic                sgn;
  logic [H_EXP_W-1:0]  hExp;
  logic [H_FRAC_W-1:0] hFrac;
  logic [LEAD_W-1:0]   leadPos;
  logic [LEAD_W-1:0]   shiftAmt;
  logic [H_FRAC_W-1:0] normFrac;
  logic [S_EXP_W-1:0]  subExp;
  logic [S_EXP_W-1:0]  resExp;
  logic [H_FRAC_W-1:0] resFrac;
  logic                isSignaling;

  assign sgn   = halfIn[H_W-1];
  assign hExp  = halfIn[H_FRAC_W +: H_EXP_W];
  assign hFrac = halfIn[H_FRAC_W-1:0];

  // Highest set fraction bit; later iterations win.
  always_comb begin
    leadPos = '0;
    for (int i = 0; i < H_FRAC_W; i++) begin
      if (hFrac[i]) leadPos = LEAD_W'(i);
    end
  end

  assign shiftAmt = LEAD_W'(H_FRAC_W) - leadPos;
  assign normFrac = H_FRAC_W'(hFrac << shiftAmt);
  assign subExp   = S_EXP_W'(BIAS_GAP + 1) - S_EXP_W'(shiftAmt);

  always_comb begin
    resExp      = '0;
    resFrac     = '0;
    isSignaling = 1'b0;
    if (hExp == '1 && !altMode) begin
      resExp  = '1;
      resFrac = hFrac;
      if (hFrac != '0) begin
        isSignaling = !hFrac[H_FRAC_W-1];
        resFrac[H_FRAC_W-1] = 1'b1;
      end
    end else if (hExp == '0) begin
      if (hFrac != '0) begin
        resExp  = subExp;
        resFrac = normFrac;
      end
    end else begin
      resExp  = S_EXP_W'(hExp) + S_EXP_W'(BIAS_GAP);
      resFrac = hFrac;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      result    <= '0;
      invalidOp <= 1'b0;
    end else if (strobe.capture) begin
      result    <= {sgn, resExp, resFrac, {FRAC_PAD{1'b0}}};
      invalidOp <= isSignaling;
    end
  end

  a_r10_hold_result: assert property (@(posedge clk) disable iff (strobe.clear)
    !strobe.capture |=> $stable(result) && $stable(invalidOp));
  a_r7_flag_is_nan: assert property (@(posedge clk) disable iff (strobe.clear)
    invalidOp |-> (result[S_W-2 -: S_EXP_W] == '1) && result[S_FRAC_W-1]);
  a_r5_nan_quiet: assert property (@(posedge clk) disable iff (strobe.clear)
    (result[S_W-2 -: S_EXP_W] == '1 && result[S_FRAC_W-1:0] != '0)
      |-> result[S_FRAC_W-1]);
  a_r3_low_bits_zero: assert property (@(posedge clk) disable iff (strobe.clear)
    result[FRAC_PAD-1:0] == '0);
  a_r9_data_cleared: assert property (@(posedge clk)
    strobe.clear |=> result == '0 && !invalidOp);
endmodule

// File: rtl/half_widen_top.sv
module half_widen_top
  import hw_pkg::*;
#(
  parameter int SRC_W    = 32,
  parameter int CTRL_W   = 32,
  parameter int MODE_BIT = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [SRC_W-1:0]  srcWord,
  input  logic              laneSel,
  input  logic [CTRL_W-1:0] fpCtrl,
  output logic [S_W-1:0]    result,
  output logic              invalidOp,
  output logic              outValid
);
  ctrlStrobe_t    strobe;
  logic [H_W-1:0] halfVal;

  hw_lane_pick #(.SRC_W(SRC_W), .LANE_W(H_W)) uLane (
    .srcWord (srcWord),
    .laneSel (laneSel),
    .laneVal (halfVal)
  );

  hw_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  hw_datapath uPath (
    .clk       (clk),
    .strobe    (strobe),
    .halfIn    (halfVal),
    .altMode   (fpCtrl[MODE_BIT]),
    .result    (result),
    .invalidOp (invalidOp)
  );
endmodule

// File: tb/half_widen_top_test.sv
module half_widen_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [31:0] srcWord;
  logic        laneSel;
  logic [31:0] fpCtrl;
  logic [31:0] result;
  logic        invalidOp;
  logic        outValid;

  int total = 0;
  int bad   = 0;

  half_widen_top uut (
    .clk(clk), .rst(rst), .inValid(inValid), .srcWord(srcWord),
    .laneSel(laneSel), .fpCtrl(fpCtrl), .result(result),
    .invalidOp(invalidOp), .outValid(outValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model: returns {invalid, single}.
  function automatic logic [32:0] model(input logic [15:0] h, input logic alt);
    logic        s;
    int          e, f, p;
    logic [31:0] r;
    logic        inv;
    s = h[15]; e = int'(h[14:10]); f = int'(h[9:0]);
    inv = 1'b0;
    if (e == 31 && !alt) begin
      r = {s, 8'hFF, (f != 0) ? (h[9:0] | 10'h200) : h[9:0], 13'b0};
      inv = (f != 0) && !h[9];
    end else if (e == 0) begin
      if (f == 0) r = {s, 31'b0};
      else begin
        p = 9;
        while (((f >> p) & 1) == 0) p--;
        r = {s, 8'(p + 103), 10'((f << (10 - p)) & 32'h3FF), 13'b0};
      end
    end else begin
      r = {s, 8'(e + 112), h[9:0], 13'b0};
    end
    return {inv, r};
  endfunction

  function automatic string tagOf(input logic [15:0] h, input logic alt, input logic lane);
    if (lane) return "R1";
    if (h[14:10] == 5'd31) return alt ? "R6" : "R5";
    if (h[14:10] == 5'd0) return (h[9:0] == 0) ? "R2" : "R4";
    return "R3";
  endfunction

  initial begin
    #(CLK_PERIOD * 190000);
    total++; bad++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] prevHalf;
    logic        prevAlt, prevLane, havePrev;
    logic [32:0] expv;
    rst = 1'b1; inValid = 1'b1; srcWord = 32'hFFFF_FFFF; laneSel = 1'b0; fpCtrl = '0;
    repeat (3) @(negedge clk);
    // R9: reset holds outputs clear even with a strobe present
    chk("R9", result, 32'h0);
    chk("R9", {31'b0, invalidOp}, 32'h0);
    chk("R9", {31'b0, outValid}, 32'h0);
    rst = 1'b0; inValid = 1'b0;
    @(negedge clk);
    havePrev = 1'b0; prevHalf = '0; prevAlt = 1'b0; prevLane = 1'b0;
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 65536; v++) begin
        @(negedge clk);
        if (havePrev) begin
          expv = model(prevHalf, prevAlt);
          chk(tagOf(prevHalf, prevAlt, prevLane), result, expv[31:0]);
          chk("R7", {31'b0, invalidOp}, {31'b0, expv[32]});
          chk("R8", {31'b0, outValid}, 32'h1);
        end
        prevHalf = 16'(v);
        prevAlt  = m[0];
        prevLane = 1'(v >> 3) ^ m[0];
        laneSel  = prevLane;
        srcWord  = prevLane ? {prevHalf, ~prevHalf ^ 16'h5A5A}
                            : {prevHalf ^ 16'h3C3C, prevHalf};
        fpCtrl   = {16'(v * 7), ~16'(v)};
        fpCtrl[26] = m[0];
        inValid  = 1'b1;
        havePrev = 1'b1;
      end
    end
    @(negedge clk);
    expv = model(prevHalf, prevAlt);
    chk(tagOf(prevHalf, prevAlt, prevLane), result, expv[31:0]);
    chk("R7", {31'b0, invalidOp}, {31'b0, expv[32]});
    // R10: inputs change with no strobe; outputs hold
    inValid = 1'b0; srcWord = 32'h7C01_7C01; fpCtrl = 32'h0; laneSel = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", result, expv[31:0]);
    chk("R10", {31'b0, invalidOp}, {31'b0, expv[32]});
    chk("R8", {31'b0, outValid}, 32'h0);
    // Single strobe: sNaN in IEEE mode, high lane
    laneSel = 1'b1; srcWord = 32'hFC01_0000; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk("R7", {31'b0, invalidOp}, 32'h1);
    chk("R5", result, 32'hFFC0_2000);
    chk("R8", {31'b0, outValid}, 32'h1);
    @(negedge clk);
    chk("R8", {31'b0, outValid}, 32'h0);
    // R9: reset mid-run clears outputs
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9", result, 32'h0);
    chk("R9", {31'b0, invalidOp}, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule